// File: doc/BRIEF.md
# Vectored Interrupt Controller with Rotating Priority

This block gathers 64 interrupt lines into one IRQ request, one FIQ request and six auxiliary request lines. Every line owns a control byte that enables it, picks level or edge sensing, and names the output it drives. Edge events are held in a status array until software clears them by writing ones. Level lines report the synchronised input directly.

Software answers an IRQ by reading a vector word. That word gives the number of the enabled, pending, IRQ-routed line with the highest priority. When no such line exists it reads 63, so software confirms a real request on line 63 through its status bit. The search order is either fixed from a programmable start index or rotating. In rotating mode each vector read that yields a line moves the start to the line just after it, so busy lines cannot starve their neighbours.

All registers sit on a simple 32-bit bus with byte strobes. Reads have one cycle of latency. Accesses must be word aligned.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset all outputs are low. Every control byte reads 0, which means disabled, level sensed and routed to IRQ. The IRQ priority word (0x20) reads 0x40, which is rotation on with start 0. The FIQ priority word (0x24) reads 0. The vector word (0x00) reads 63.
- R2: The control byte of line n sits in byte lane n%4 of word 0x40+4*(n/4). A write changes only the lanes whose strobe is set. All 8 bits read back as written. Bit 3 is enable, bits 6:5 are the trigger and bits 2:0 are the destination.
- R3: With trigger 00 the line is level sensed. Its status bit (word 0x80 holds lines 0-31, word 0x84 holds lines 32-63, bit n%32) follows the synchronised input, and writing 1 to that bit has no effect.
- R4: With trigger 01 (bit 5) a rising edge sets the status bit and it stays set. Writing 1 to the bit clears it, and writing 0 leaves it set.
- R5: With trigger 10 (bit 6) only a falling edge sets the status bit. With 11 both edges set it.
- R6: An edge is latched even while the line is disabled. A disabled line drives no output. Enabling it later with its event still latched raises its output.
- R7: Destination 0 drives irq_o, 1 drives fiq_o and k in 2..7 drives aux_o[k-2]. Each output is the registered OR of the enabled, pending lines routed to it.
- R8: Word 0x00 returns the winning line number in bits 5:0, with bits 31:6 zero. It returns 63 when no enabled, pending line is routed to IRQ.
- R9: With bit 6 of word 0x20 clear, the search starts at the index in bits 5:0, rises and wraps. Start 0 means the lowest-numbered line wins. Vector reads do not move the start.
- R10: With bit 6 set, a vector read that yields line w sets the start to w+1, wrapping modulo 64. The next read therefore yields the next pending line after w.
- R11: If an edge is detected in the same cycle as a 1 is written to that line's status bit, the event stays latched.
- R12: Word 0x24 stores 7 bits that read back as written and do not affect the vector or any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte lane enables for writes |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_in | input | 64 | Raw interrupt lines |
| irq_o | output | 1 | IRQ request |
| fiq_o | output | 1 | FIQ request |
| aux_o | output | 6 | Auxiliary request lines |

## Verification
Two events can land in the same cycle: a new edge being latched and a software write-one-to-clear of the same status bit. The bench first latches an event on a rising-edge line and lets the line fall. It then raises the line again and times the clear write so that the write is sampled on the exact clock edge at which the synchroniser and edge detector set the latch. The status word is read afterwards and must still show the bit set. A second clear, with no new edge, must then clear it, which shows the write itself was effective.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  // register offsets (byte addresses)
  localparam int VEC_OFS     = 'h00;
  localparam int IRQ_PC_OFS  = 'h20;
  localparam int FIQ_PC_OFS  = 'h24;
  localparam int CTRL_OFS    = 'h40;
  localparam int STAT_OFS    = 'h80;
  // control byte fields
  localparam int EN_BIT      = 3;
  localparam int RISE_BIT    = 5;
  localparam int FALL_BIT    = 6;
  // priority word
  localparam int ROT_BIT     = 6;
  localparam int FIQ_PC_W    = 7;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic clr_i,
  output logic pend_o
);
  logic s1_q, s2_q, prev_q, lat_q;
  logic hit, level;

  assign hit   = (rise_en_i & s2_q & ~prev_q) | (fall_en_i & ~s2_q & prev_q);
  assign level = ~(rise_en_i | fall_en_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      // a fresh event outranks a same-cycle clear
      lat_q  <= (lat_q & ~clr_i) | hit;
    end
  end

  assign pend_o = level ? s2_q : lat_q;
endmodule

// File: rtl/irq_rot_picker.sv
module irq_rot_picker #(
  parameter int N_REQ = 64,
  localparam int IDX_W = $clog2(N_REQ)
) (
  input  logic [N_REQ-1:0] req_i,
  input  logic [IDX_W-1:0] start_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  logic [IDX_W-1:0] pos;

  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    pos   = '0;
    for (int i = 0; i < N_REQ; i++) begin
      pos = start_i + IDX_W'(i);
      if (!vld_o && req_i[pos]) begin
        idx_o = pos;
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int N_AUX  = 6,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_wstrb,
  output logic [31:0]       bus_rdata,
  input  logic [N_SRC-1:0]  src_in,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [N_AUX-1:0]  aux_o
);
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int N_DEST = 2 + N_AUX;
  localparam int DEST_W = $clog2(N_DEST);
  localparam int N_CW   = N_SRC / 4;
  localparam int N_SW   = N_SRC / 32;

  logic [7:0]         ctrl_q [N_SRC];
  logic [N_SRC-1:0]   pend, clr, active;
  logic [N_SRC-1:0]   dest_mask [N_DEST];
  logic [N_DEST-1:0]  dest_any;
  logic               rot_q;
  logic [IDX_W-1:0]   start_q;
  logic [FIQ_PC_W-1:0] fiq_pc_q;
  logic [IDX_W-1:0]   winner;
  logic               win_vld;
  logic [IDX_W-1:0]   vec;
  logic [31:0]        rd_mux;
  logic               vec_rd, irq_pc_wr, fiq_pc_wr;

  assign vec_rd    = bus_rd && (bus_addr == ADDR_W'(VEC_OFS));
  assign irq_pc_wr = bus_wr && (bus_addr == ADDR_W'(IRQ_PC_OFS)) && bus_wstrb[0];
  assign fiq_pc_wr = bus_wr && (bus_addr == ADDR_W'(FIQ_PC_OFS)) && bus_wstrb[0];

  // per-source control byte, edge/level cell and routing
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    localparam int LANE = g % 4;
    localparam int BITP = g % 32;
    localparam logic [ADDR_W-1:0] CW_ADDR = ADDR_W'(CTRL_OFS + (g / 4) * 4);
    localparam logic [ADDR_W-1:0] SW_ADDR = ADDR_W'(STAT_OFS + (g / 32) * 4);

    always_ff @(posedge clk) begin
      if (rst) ctrl_q[g] <= '0;
      else if (bus_wr && bus_addr == CW_ADDR && bus_wstrb[LANE])
        ctrl_q[g] <= bus_wdata[8*LANE +: 8];
    end

    assign clr[g] = bus_wr && (bus_addr == SW_ADDR) && bus_wstrb[BITP/8] && bus_wdata[BITP];

    irq_src_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .src_i     (src_in[g]),
      .rise_en_i (ctrl_q[g][RISE_BIT]),
      .fall_en_i (ctrl_q[g][FALL_BIT]),
      .clr_i     (clr[g]),
      .pend_o    (pend[g])
    );

    assign active[g] = pend[g] & ctrl_q[g][EN_BIT];

    for (genvar d = 0; d < N_DEST; d++) begin : g_dst
      assign dest_mask[d][g] = active[g] && (ctrl_q[g][DEST_W-1:0] == DEST_W'(d));
    end
  end

  for (genvar d = 0; d < N_DEST; d++) begin : g_any
    assign dest_any[d] = |dest_mask[d];
  end

  irq_rot_picker #(.N_REQ(N_SRC)) u_pick (
    .req_i   (dest_mask[0]),
    .start_i (start_q),
    .idx_o   (winner),
    .vld_o   (win_vld)
  );

  assign vec = win_vld ? winner : '1;

  // priority control words
  always_ff @(posedge clk) begin
    if (rst) begin
      rot_q    <= 1'b1;
      start_q  <= '0;
      fiq_pc_q <= '0;
    end else begin
      if (irq_pc_wr) begin
        rot_q   <= bus_wdata[ROT_BIT];
        start_q <= bus_wdata[IDX_W-1:0];
      end else if (vec_rd && rot_q && win_vld) begin
        start_q <= winner + 1'b1;
      end
      if (fiq_pc_wr) fiq_pc_q <= bus_wdata[FIQ_PC_W-1:0];
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(VEC_OFS)) rd_mux[IDX_W-1:0] = vec;
    if (bus_addr == ADDR_W'(IRQ_PC_OFS)) begin
      rd_mux[ROT_BIT]     = rot_q;
      rd_mux[IDX_W-1:0]   = start_q;
    end
    if (bus_addr == ADDR_W'(FIQ_PC_OFS)) rd_mux[FIQ_PC_W-1:0] = fiq_pc_q;
    for (int w = 0; w < N_CW; w++)
      if (bus_addr == ADDR_W'(CTRL_OFS + 4 * w))
        rd_mux = {ctrl_q[4*w+3], ctrl_q[4*w+2], ctrl_q[4*w+1], ctrl_q[4*w]};
    for (int s = 0; s < N_SW; s++)
      if (bus_addr == ADDR_W'(STAT_OFS + 4 * s))
        rd_mux = pend[32*s +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
      aux_o     <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_o <= dest_any[0];
      fiq_o <= dest_any[1];
      aux_o <= dest_any[N_DEST-1:2];
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int N_SRC  = 64,
  parameter int N_AUX  = 6,
  parameter int ADDR_W = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [N_AUX-1:0]  aux_o,
  input logic              rot_q,
  input logic [IDX_W-1:0]  start_q,
  input logic [IDX_W-1:0]  winner,
  input logic              win_vld
);
  logic rst_d = 1'b0;
  logic vec_rd, pc_wr;
  assign vec_rd = bus_rd && (bus_addr == ADDR_W'(0));
  assign pc_wr  = bus_wr && (bus_addr == ADDR_W'('h20));

  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    // R1
    if (rst_d) reset_quiet_chk: assert (!irq_o && !fiq_o && aux_o == '0);
  end

  // R8
  vec_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    vec_rd |=> bus_rdata[31:IDX_W] == '0);

  // R8
  idle_vector_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && !win_vld) |=> bus_rdata[IDX_W-1:0] == '1);

  // R9
  fixed_start_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (!rot_q && !pc_wr) |=> $stable(start_q));

  // R10
  rotate_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && rot_q && win_vld && !pc_wr) |=> start_q == $past(winner) + 1'b1);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.N_SRC(N_SRC), .N_AUX(N_AUX), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/irq_vec_ctrl_bench.sv
`timescale 1ns/1ps
module irq_vec_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq_o, fiq_o;
  logic [5:0]  aux_o;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irq_vec_ctrl u_irq_vec_ctrl (
    .clk, .rst, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_wstrb,
    .bus_rdata, .src_in, .irq_o, .fiq_o, .aux_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_wr = 1'b0; bus_wstrb = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic set_ctrl(input int n, input logic [7:0] v);
    wr(8'(8'h40 + (n / 4) * 4), 32'(v) << (8 * (n % 4)), 4'(1 << (n % 4)));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    chk("R1 aux_o", 32'(aux_o), 0);
    rd(8'h20, d); chk("R1 irq prio word", d, 32'h40);
    rd(8'h24, d); chk("R1 fiq prio word", d, 0);
    rd(8'h00, d); chk("R1 vector idle", d, 63);
    rd(8'h40, d); chk("R1 ctrl word 0", d, 0);
    rd(8'h84, d); chk("R1 status word 1", d, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    set_ctrl(5, 8'h6A);
    rd(8'h44, d); chk("R2 single lane", d, 32'h0000_6A00);
    wr(8'h7C, 32'hA1B2_C3D4);
    rd(8'h7C, d); chk("R2 full word", d, 32'hA1B2_C3D4);
    wr(8'h7C, 32'h0000_0000, 4'b0110);
    rd(8'h7C, d); chk("R2 strobe mask", d, 32'hA100_00D4);
    wr(8'h7C, 0); set_ctrl(5, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    set_ctrl(10, 8'h08);
    src_in[10] = 1'b1; idle(5);
    chk("R3 level irq_o", 32'(irq_o), 1);
    wr(8'h80, 32'h1 << 10); idle(2);
    rd(8'h80, d); chk("R3 w1c ignored on level", 32'(d[10]), 1);
    src_in[10] = 1'b0; idle(5);
    rd(8'h80, d); chk("R3 level follows input", 32'(d[10]), 0);
    chk("R7 irq_o drops", 32'(irq_o), 0);
    set_ctrl(10, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    set_ctrl(20, 8'h28);
    src_in[20] = 1'b1; idle(5);
    src_in[20] = 1'b0; idle(5);
    rd(8'h80, d); chk("R4 edge latched", 32'(d[20]), 1);
    chk("R4 irq_o held", 32'(irq_o), 1);
    wr(8'h80, 32'h0); idle(2);
    rd(8'h80, d); chk("R4 zero write keeps", 32'(d[20]), 1);
    wr(8'h80, 32'h1 << 20); idle(3);
    rd(8'h80, d); chk("R4 w1c clears", 32'(d[20]), 0);
    chk("R4 irq_o cleared", 32'(irq_o), 0);
    set_ctrl(20, 0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    set_ctrl(33, 8'h48);
    src_in[33] = 1'b1; idle(5);
    rd(8'h84, d); chk("R5 rise ignored", 32'(d[1]), 0);
    src_in[33] = 1'b0; idle(5);
    rd(8'h84, d); chk("R5 fall latched", 32'(d[1]), 1);
    wr(8'h84, 32'h2);
    set_ctrl(33, 8'h68); idle(2);
    rd(8'h84, d); chk("R5 cleared", 32'(d[1]), 0);
    src_in[33] = 1'b1; idle(5);
    rd(8'h84, d); chk("R5 both edges rise", 32'(d[1]), 1);
    wr(8'h84, 32'h2); idle(2);
    src_in[33] = 1'b0; idle(5);
    rd(8'h84, d); chk("R5 both edges fall", 32'(d[1]), 1);
    wr(8'h84, 32'h2); set_ctrl(33, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    set_ctrl(40, 8'h20);
    src_in[40] = 1'b1; idle(5);
    chk("R6 disabled no irq", 32'(irq_o), 0);
    rd(8'h84, d); chk("R6 latched while off", 32'(d[8]), 1);
    set_ctrl(40, 8'h28); idle(3);
    chk("R6 enable raises irq", 32'(irq_o), 1);
    rd(8'h00, d); chk("R8 vector line 40", d, 40);
    src_in[40] = 1'b0;
    wr(8'h84, 32'h1 << 8); set_ctrl(40, 0); idle(3);
  endtask

  task automatic t_route();
    logic [31:0] d;
    set_ctrl(2, 8'h09);
    set_ctrl(50, 8'h0C);
    src_in[2] = 1'b1; src_in[50] = 1'b1; idle(5);
    chk("R7 fiq_o", 32'(fiq_o), 1);
    chk("R7 aux_o lane 2", 32'(aux_o), 32'h4);
    chk("R7 irq_o idle", 32'(irq_o), 0);
    rd(8'h00, d); chk("R8 no irq line -> 63", d, 63);
    src_in[2] = 1'b0; src_in[50] = 1'b0;
    set_ctrl(2, 0); set_ctrl(50, 0); idle(4);
    chk("R7 aux_o clear", 32'(aux_o), 0);
  endtask

  task automatic t_fixed();
    logic [31:0] d;
    wr(8'h20, 32'h00);
    set_ctrl(7, 8'h08); set_ctrl(12, 8'h08); set_ctrl(45, 8'h08);
    src_in[7] = 1'b1; src_in[12] = 1'b1; src_in[45] = 1'b1; idle(5);
    rd(8'h00, d); chk("R9 lowest wins", d, 7);
    rd(8'h00, d); chk("R9 read does not move", d, 7);
    wr(8'h20, 32'h0A);
    rd(8'h00, d); chk("R9 start 10", d, 12);
    wr(8'h20, 32'h2E);
    rd(8'h00, d); chk("R9 start 46 wraps", d, 7);
    wr(8'h24, 32'h55);
    rd(8'h24, d); chk("R12 fiq prio readback", d, 32'h55);
    rd(8'h00, d); chk("R12 vector unaffected", d, 7);
    chk("R12 fiq_o unaffected", 32'(fiq_o), 0);
  endtask

  task automatic t_rotate();
    logic [31:0] d;
    wr(8'h20, 32'h40);
    rd(8'h00, d); chk("R10 first", d, 7);
    rd(8'h00, d); chk("R10 second", d, 12);
    rd(8'h00, d); chk("R10 third", d, 45);
    rd(8'h00, d); chk("R10 wrap", d, 7);
    rd(8'h20, d); chk("R10 start after 7", d, 32'h48);
    wr(8'h20, 32'h7F);
    rd(8'h00, d); chk("R10 start 63 wraps", d, 7);
    src_in[7] = 1'b0; src_in[12] = 1'b0; src_in[45] = 1'b0;
    set_ctrl(7, 0); set_ctrl(12, 0); set_ctrl(45, 0); idle(3);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    set_ctrl(25, 8'h20);
    src_in[25] = 1'b1; idle(5);
    src_in[25] = 1'b0; idle(5);
    src_in[25] = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(8'h80, 32'h1 << 25); idle(2);
    rd(8'h80, d); chk("R11 edge beats clear", 32'(d[25]), 1);
    wr(8'h80, 32'h1 << 25); idle(2);
    rd(8'h80, d); chk("R11 later clear works", 32'(d[25]), 0);
    src_in[25] = 1'b0; set_ctrl(25, 0);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_ctrl();
    t_level();
    t_rise();
    t_fall();
    t_disabled();
    t_route();
    t_fixed();
    t_rotate();
    t_same_cycle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule